// File: doc/BRIEF.md
# Octal Double-Rate PSRAM Transaction Engine

This block runs one memory transaction at a time against an external pseudo-static RAM that talks over eight data lines, with a byte moving on every edge of the serial clock. A request carries an operation type, a 32-bit address, a byte count and up to four bytes of write data. The engine drives chip select, the serial clock and the octal lines with their output enable. It then walks the phases in a fixed order: chip-select setup, a 16-bit command, a 32-bit address, an optional dummy stretch, the data bytes, chip-select hold, and a minimum deselect gap.

One system clock carries one byte, and the serial clock toggles once per system clock during the command, address, dummy and data phases. A serial-clock period therefore spans two bytes. The 16-bit command takes one serial clock and the address takes two. Read bytes are sampled from the input lines at the end of each data-phase clock. They are returned together with a one-cycle done strobe. Only one request is in flight at a time, and the ready output stalls any request made while a transaction is in progress.

Top module: `psram_octal_engine`

## Requirements
- R1: A request is taken only in a cycle where `reqReady` is high. `reqReady` is high only while the engine is idle and chip select is deasserted. A request held while busy waits, and is taken on the first idle cycle.
- R2: The command phase lasts two clocks and drives the upper command byte, then the lower one. The codes are 16'h0000 for op 0 (memory read), 16'h8080 for op 1 (memory write), 16'h4040 for op 2 (register read) and 16'hC0C0 for op 3 (register write).
- R3: The address phase lasts four clocks and drives `reqAddr` with the most significant byte first.
- R4: Ops 0 and 2 insert RD_DUMMY (default 18) dummy clocks. Op 1 inserts WR_DUMMY (default 8). Op 3 inserts none. `dqOe` is low during the dummy clocks and during the data clocks of a read.
- R5: Write data is driven with byte k taken from `reqWdata[8k+7:8k]`, byte 0 first and without swapping. For an odd length, one extra 8'h00 byte completes the last clock period. Request bytes at or beyond the length are never driven.
- R6: In a read, data byte k is sampled from `dqIn` at the end of data clock k and returned in `rspRdata[8k+7:8k]`. Bytes at or beyond the requested length, including the pad clock of an odd-length read, read as zero.
- R7: Chip select (`csN`, active low) is asserted CS_SETUP clocks (default 3) before the first command clock with `sclk` low. It stays asserted CS_HOLD clocks (default 3) after the last data clock, also with `sclk` low.
- R8: Between transactions `csN` stays high for at least CS_GAP clocks (default 2). For back-to-back requests it stays high for exactly CS_GAP+1 clocks.
- R9: `sclk` is low whenever `csN` is high. In the active phases it starts low on the first command clock and toggles every clock, so it ends low.
- R10: `rspDone` pulses for exactly one clock, in the first hold clock, and `rspRdata` is final in that cycle.
- R11: After reset `csN` is high, `sclk`, `dqOe` and `rspDone` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one byte per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqOp | input | 2 | 0 memory read, 1 memory write, 2 register read, 3 register write |
| reqAddr | input | 32 | Transaction address |
| reqLen | input | 3 | Byte count, 1 to MAX_BYTES |
| reqWdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| rspDone | output | 1 | One-cycle completion strobe |
| rspRdata | output | 32 | Read bytes, byte 0 in bits 7:0 |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dqOut | output | 8 | Octal output lines |
| dqOe | output | 1 | Output enable for the octal lines |
| dqIn | input | 8 | Octal input lines |

## Verification
A phase counter that is off by one shows up at the pins in the very transaction where it goes wrong. The command, address or data bytes land one clock early or late, and the chip-select low window has the wrong length. A wrong dummy selection moves every read byte to a neighbouring sample, and those values are tagged by cycle index, so the returned word differs on the first affected read. A stuck latched operation shows up as the wrong command byte on the first command clock. A broken gap or ready handshake shows up as a deselect run of the wrong length between back-to-back requests.

// File: rtl/psram_octal_pkg.sv
package psram_octal_pkg;

  typedef enum logic [1:0] {
    OP_MEM_RD = 2'd0,
    OP_MEM_WR = 2'd1,
    OP_REG_RD = 2'd2,
    OP_REG_WR = 2'd3
  } op_e;

  // Strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic shiftOut;  // advance the outgoing byte stream
    logic capture;   // store the incoming byte
    logic driveBus;  // octal lines driven
    logic csActive;  // chip select asserted
    logic clkRun;    // serial clock toggling
  } strobe_t;

  function automatic logic [15:0] cmdWord(op_e op);
    case (op)
      OP_MEM_RD: return 16'h0000;
      OP_MEM_WR: return 16'h8080;
      OP_REG_RD: return 16'h4040;
      default:   return 16'hC0C0;
    endcase
  endfunction

  function automatic logic isWriteOp(op_e op);
    return (op == OP_MEM_WR) || (op == OP_REG_WR);
  endfunction

endpackage

// File: rtl/psram_octal_ctrl.sv
module psram_octal_ctrl
  import psram_octal_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int RD_DUMMY  = 18,
  parameter int WR_DUMMY  = 8,
  parameter int CS_SETUP  = 3,
  parameter int CS_HOLD   = 3,
  parameter int CS_GAP    = 2,
  parameter int LW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  op_e           reqOp,
  input  logic [LW-1:0] reqLen,
  output logic          reqReady,
  output strobe_t       stb,
  output logic [LW-1:0] byteIdx,
  output logic          done
);

  localparam int M1 = (RD_DUMMY > WR_DUMMY) ? RD_DUMMY : WR_DUMMY;
  localparam int M2 = (M1 > CS_SETUP) ? M1 : CS_SETUP;
  localparam int M3 = (M2 > CS_HOLD) ? M2 : CS_HOLD;
  localparam int M4 = (M3 > CS_GAP) ? M3 : CS_GAP;
  localparam int M5 = (M4 > MAX_BYTES + 1) ? M4 : MAX_BYTES + 1;
  localparam int CW = $clog2(M5 + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_HOLD, ST_GAP
  } state_e;

  state_e        stateQ;
  logic [CW-1:0] cntQ;
  op_e           opQ;
  logic [LW-1:0] lenQ;
  logic [LW-1:0] byteIdxQ;
  logic          doneQ;
  logic [CW-1:0] dummyLen;
  logic [CW-1:0] dataLast;
  logic          isWrite;

  assign isWrite  = isWriteOp(opQ);
  assign dataLast = CW'(lenQ) + CW'(lenQ[0]) - ONE;

  always_comb begin
    case (opQ)
      OP_MEM_RD, OP_REG_RD: dummyLen = CW'(RD_DUMMY);
      OP_MEM_WR:            dummyLen = CW'(WR_DUMMY);
      default:              dummyLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      opQ      <= OP_MEM_RD;
      lenQ     <= '0;
      byteIdxQ <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: if (reqValid) begin
          opQ    <= reqOp;
          lenQ   <= reqLen;
          cntQ   <= CW'(CS_SETUP - 1);
          stateQ <= ST_SETUP;
        end
        ST_SETUP: if (cntQ == '0) begin
          stateQ <= ST_CMD;
          cntQ   <= ONE;
        end else cntQ <= cntQ - ONE;
        ST_CMD: if (cntQ == '0) begin
          stateQ <= ST_ADDR;
          cntQ   <= CW'(3);
        end else cntQ <= cntQ - ONE;
        ST_ADDR: if (cntQ == '0) begin
          byteIdxQ <= '0;
          if (dummyLen != '0) begin
            stateQ <= ST_DUMMY;
            cntQ   <= dummyLen - ONE;
          end else begin
            stateQ <= ST_DATA;
            cntQ   <= dataLast;
          end
        end else cntQ <= cntQ - ONE;
        ST_DUMMY: if (cntQ == '0) begin
          stateQ <= ST_DATA;
          cntQ   <= dataLast;
        end else cntQ <= cntQ - ONE;
        ST_DATA: begin
          byteIdxQ <= byteIdxQ + LW'(1);
          if (cntQ == '0) begin
            stateQ <= ST_HOLD;
            cntQ   <= CW'(CS_HOLD - 1);
            doneQ  <= 1'b1;
          end else cntQ <= cntQ - ONE;
        end
        ST_HOLD: if (cntQ == '0) begin
          stateQ <= ST_GAP;
          cntQ   <= CW'(CS_GAP - 1);
        end else cntQ <= cntQ - ONE;
        default: if (cntQ == '0) stateQ <= ST_IDLE;
                 else cntQ <= cntQ - ONE;
      endcase
    end
  end

  always_comb begin
    reqReady     = (stateQ == ST_IDLE);
    stb.load     = reqReady && reqValid;
    stb.shiftOut = (stateQ == ST_CMD) || (stateQ == ST_ADDR) ||
                   ((stateQ == ST_DATA) && isWrite);
    stb.driveBus = stb.shiftOut;
    stb.capture  = (stateQ == ST_DATA) && !isWrite && (byteIdxQ < lenQ);
    stb.csActive = (stateQ != ST_IDLE) && (stateQ != ST_GAP);
    stb.clkRun   = (stateQ == ST_CMD) || (stateQ == ST_ADDR) ||
                   (stateQ == ST_DUMMY) || (stateQ == ST_DATA);
  end

  assign byteIdx = byteIdxQ;
  assign done    = doneQ;

endmodule

// File: rtl/psram_octal_datapath.sv
module psram_octal_datapath
  import psram_octal_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int LW        = 3,
  localparam int DW       = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  op_e           reqOp,
  input  logic [31:0]   reqAddr,
  input  logic [LW-1:0] reqLen,
  input  logic [DW-1:0] reqWdata,
  input  logic [LW-1:0] byteIdx,
  input  logic [7:0]    dqIn,
  output logic [7:0]    dqOut,
  output logic          sclk,
  output logic [DW-1:0] rdata
);

  localparam int TW = 48 + DW;

  logic [TW-1:0] txQ;
  logic [DW-1:0] dataPacked;
  logic          sclkQ;
  logic [DW-1:0] rdataQ;

  // First data byte sits in the top byte; bytes past the length are zero
  always_comb begin
    for (int k = 0; k < MAX_BYTES; k++) begin
      dataPacked[(MAX_BYTES-1-k)*8 +: 8] =
        (LW'(k) < reqLen) ? reqWdata[k*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ    <= '0;
      sclkQ  <= 1'b0;
      rdataQ <= '0;
    end else begin
      sclkQ <= stb.clkRun ? ~sclkQ : 1'b0;
      if (stb.load) begin
        txQ    <= {cmdWord(reqOp), reqAddr, dataPacked};
        rdataQ <= '0;
      end else begin
        if (stb.shiftOut) txQ <= {txQ[TW-9:0], 8'h00};
        for (int k = 0; k < MAX_BYTES; k++) begin
          if (stb.capture && (byteIdx == LW'(k))) rdataQ[k*8 +: 8] <= dqIn;
        end
      end
    end
  end

  assign dqOut = txQ[TW-1 -: 8];
  assign sclk  = sclkQ;
  assign rdata = rdataQ;

endmodule

// File: rtl/psram_octal_engine.sv
module psram_octal_engine
  import psram_octal_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int RD_DUMMY  = 18,
  parameter int WR_DUMMY  = 8,
  parameter int CS_SETUP  = 3,
  parameter int CS_HOLD   = 3,
  parameter int CS_GAP    = 2,
  localparam int DW       = 8 * MAX_BYTES,
  localparam int LW       = $clog2(MAX_BYTES + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [1:0]    reqOp,
  input  logic [31:0]   reqAddr,
  input  logic [LW-1:0] reqLen,
  input  logic [DW-1:0] reqWdata,
  output logic          rspDone,
  output logic [DW-1:0] rspRdata,
  output logic          csN,
  output logic          sclk,
  output logic [7:0]    dqOut,
  output logic          dqOe,
  input  logic [7:0]    dqIn
);

  strobe_t       stb;
  logic [LW-1:0] byteIdx;
  op_e           opIn;

  assign opIn = op_e'(reqOp);

  psram_octal_ctrl #(
    .MAX_BYTES(MAX_BYTES), .RD_DUMMY(RD_DUMMY), .WR_DUMMY(WR_DUMMY),
    .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD), .CS_GAP(CS_GAP), .LW(LW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opIn),
    .reqLen(reqLen), .reqReady(reqReady), .stb(stb), .byteIdx(byteIdx),
    .done(rspDone)
  );

  psram_octal_datapath #(.MAX_BYTES(MAX_BYTES), .LW(LW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(opIn), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWdata(reqWdata), .byteIdx(byteIdx), .dqIn(dqIn),
    .dqOut(dqOut), .sclk(sclk), .rdata(rspRdata)
  );

  assign csN  = ~stb.csActive;
  assign dqOe = stb.driveBus;

endmodule

// File: rtl/psram_octal_checker.sv
module psram_octal_checker #(
  parameter int CS_SETUP = 3,
  parameter int CS_GAP   = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic csN,
  input logic sclk,
  input logic dqOe,
  input logic rspDone
);

  logic [7:0] highRun;
  logic [7:0] lowRun;
  logic       csNQ;
  logic       seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun  <= '0;
      lowRun   <= '0;
      csNQ     <= 1'b1;
      seenRise <= 1'b0;
    end else begin
      csNQ     <= csN;
      seenRise <= seenRise | (csN & ~csNQ);
      highRun  <= csN ? ((highRun == 8'hFF) ? highRun : highRun + 8'd1) : 8'd0;
      lowRun   <= csN ? 8'd0 : ((lowRun == 8'hFF) ? lowRun : lowRun + 8'd1);
    end
  end

  assert_ready_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  assert_bus_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !csN);

  assert_setup_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> (lowRun > 8'(CS_SETUP)));

  assert_deselect_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && seenRise) |-> (highRun >= 8'(CS_GAP)));

  assert_clock_parked_R9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind psram_octal_engine psram_octal_checker #(
  .CS_SETUP(CS_SETUP), .CS_GAP(CS_GAP)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .csN(csN), .sclk(sclk),
  .dqOe(dqOe), .rspDone(rspDone)
);

// File: tb/psram_octal_engine_tb_top.sv
module psram_octal_engine_tb_top;

  localparam int SET = 3;
  localparam int HLD = 3;
  localparam int GAP = 2;
  localparam int RDD = 18;
  localparam int WRD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqLen = 3'd0;
  logic [31:0] reqWdata = '0;
  logic        rspDone;
  logic [31:0] rspRdata;
  logic        csN;
  logic        sclk;
  logic [7:0]  dqOut;
  logic        dqOe;
  logic [7:0]  dqIn = 8'h00;

  always #2 clk = ~clk;

  psram_octal_engine dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .csN(csN), .sclk(sclk),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  typedef struct {
    int          op;
    logic [31:0] addr;
    int          len;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic [7:0]  salt;
    bit          b2b;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;

  function automatic int dummyOf(int op);
    return (op == 0 || op == 2) ? RDD : (op == 1 ? WRD : 0);
  endfunction

  function automatic logic [15:0] cmdOf(int op);
    case (op)
      0: return 16'h0000;
      1: return 16'h8080;
      2: return 16'h4040;
      default: return 16'hC0C0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: pushes the expected item, then holds the request until taken
  task automatic issue(int op, logic [31:0] addr, int len, logic [31:0] wdata,
                       logic [7:0] salt, bit b2b);
    item_t it;
    it.op = op; it.addr = addr; it.len = len; it.wdata = wdata;
    it.salt = salt; it.b2b = b2b; it.expRd = '0;
    if (op == 0 || op == 2)
      for (int k = 0; k < len; k++)
        it.expRd[8*k +: 8] = 8'(SET + 6 + dummyOf(op) + k) ^ salt;
    q.push_back(it);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = addr;
    reqLen = 3'(len); reqWdata = wdata;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares pins cycle by cycle and the response on done
  int    cyc = 0;
  int    highRun = 0;
  bit    prevCs = 1'b1;
  bit    pinBad = 1'b0;
  string badTag = "R7";
  logic [31:0] badAct, badExp;

  always @(negedge clk) begin
    if (rstN) begin
      if (!csN) begin
        if (q.size() == 0) begin
          chk(0, "R1", "transaction without request", 32'd1, 32'd0);
        end else begin
          item_t c;
          int d, n, a, k;
          bit eOe, eSclk;
          logic [7:0] eDq;
          string tag;
          c = q[0];
          d = dummyOf(c.op);
          n = c.len + (c.len % 2);
          a = cyc - SET;
          if (prevCs && c.b2b)
            chk(highRun == GAP + 1, "R8", "deselect run", 32'(highRun), 32'(GAP + 1));
          eOe = 1'b0; eSclk = 1'b0; eDq = 8'h00; tag = "R7";
          if (cyc >= SET && a < 6 + d + n) begin
            eSclk = 1'(a % 2);
            if (a < 2) begin
              eOe = 1'b1; tag = "R2";
              eDq = (a == 0) ? cmdOf(c.op)[15:8] : cmdOf(c.op)[7:0];
            end else if (a < 6) begin
              eOe = 1'b1; tag = "R3"; eDq = c.addr[8*(5-a) +: 8];
            end else if (a < 6 + d) begin
              tag = "R4";
            end else begin
              k = a - 6 - d;
              if (c.op == 1 || c.op == 3) begin
                eOe = 1'b1; tag = "R5";
                eDq = (k < c.len) ? c.wdata[8*k +: 8] : 8'h00;
              end else tag = "R4";
            end
          end
          if (sclk !== eSclk) tag = "R9";
          if (!pinBad && (dqOe !== eOe || sclk !== eSclk || (eOe && dqOut !== eDq))) begin
            pinBad = 1'b1; badTag = tag;
            badAct = {cyc[7:0], 6'd0, sclk, dqOe, 8'd0, dqOut};
            badExp = {cyc[7:0], 6'd0, eSclk, eOe, 8'd0, eDq};
          end
          if (rspDone) begin
            chk(cyc == SET + 6 + d + n, "R10", "done cycle", 32'(cyc), 32'(SET + 6 + d + n));
            if (c.op == 0 || c.op == 2)
              chk(rspRdata === c.expRd, "R6", "read data", rspRdata, c.expRd);
            chk(reqReady == 1'b0, "R1", "ready while busy", 32'(reqReady), 32'd0);
          end
          dqIn = 8'(cyc) ^ c.salt;
        end
        cyc++;
      end else begin
        if (!prevCs && q.size() != 0) begin
          item_t c;
          int tot;
          c = q.pop_front();
          tot = SET + 6 + dummyOf(c.op) + c.len + (c.len % 2) + HLD;
          chk(cyc == tot, "R7", "select window", 32'(cyc), 32'(tot));
          chk(!pinBad, badTag, "pin trace", badAct, badExp);
          pinBad = 1'b0; badTag = "R7";
          cyc = 0; highRun = 0;
        end
        if (sclk !== 1'b0 || dqOe !== 1'b0)
          chk(0, "R9", "deselected pins", {30'd0, sclk, dqOe}, 32'd0);
        highRun++;
      end
      prevCs = csN;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(csN === 1'b1, "R11", "csN", 32'(csN), 32'd1);
    chk(sclk === 1'b0, "R11", "sclk", 32'(sclk), 32'd0);
    chk(dqOe === 1'b0, "R11", "dqOe", 32'(dqOe), 32'd0);
    chk(rspDone === 1'b0, "R11", "rspDone", 32'(rspDone), 32'd0);
    chk(reqReady === 1'b1, "R11", "reqReady", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    issue(1, 32'h1234_5678, 4, 32'hDDCC_BBAA, 8'h00, 1'b0);  // R5 full write
    repeat (40) @(negedge clk);
    issue(0, 32'h00AB_CDEF, 4, 32'h0, 8'h5A, 1'b0);          // R6 full read
    repeat (40) @(negedge clk);
    issue(3, 32'h0000_0000, 2, 32'hFFFF_3021, 8'h00, 1'b0);  // R4 no dummy, R5 masking
    repeat (30) @(negedge clk);
    issue(2, 32'h0000_0008, 1, 32'h0, 8'hC3, 1'b0);          // R6 odd register read
    repeat (40) @(negedge clk);
    issue(1, 32'hF0E0_D0C0, 3, 32'h7766_5544, 8'h00, 1'b0);  // R5 odd write pad
    issue(0, 32'h0000_0400, 2, 32'h0, 8'h3C, 1'b1);          // R1/R8 back-to-back
    issue(2, 32'h0000_0002, 2, 32'h0, 8'h96, 1'b1);          // R8 back-to-back
    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule